// File: doc/BRIEF.md
# Majority-vote SPI receive sampler

This block sits in the receive path of a register-programmable SPI master. It does not trust a single sample of the slave's data line. On every system clock between two shifting edges of SCK it samples MISO and counts the high samples. At each shifting edge it turns that count into one bit by a majority decision against the prescaler setting. The decided bits enter a receive shift register, most significant bit first. When the programmed number of bits has arrived, the finished word is published on a holding output together with a one-clock completion pulse.

The master's prescaler and edge logic supply a start pulse for each transfer and one pulse per SCK edge. The receive side needs three settings: the prescaler maximum value p, which gives p+1 system clocks per SCK half-period; the edge-role selector; and the word length minus one. All three are captured when a transfer starts. A short spike on MISO, of up to p samples within one bit, cannot flip the bit.

Top module: `spi_rx_vote`

## Requirements
- R1: After reset, rx_word_o is all zeros and word_done_o is low.
- R2: Every bit is decided from the MISO samples taken on the system clocks that lie strictly between two successive clears. With the edges p+1 clocks apart, that is 2p+1 samples. The bit is 1 exactly when the number of high samples is greater than p: p+1 highs give 1 and p highs give 0. The accumulator saturates and never wraps.
- R3: The sample accumulator is cleared in the start cycle and in every shifting-edge cycle. The MISO level in those cycles, and any level seen before the start, does not count toward any bit.
- R4: SCK edges are numbered from 1 after the start. With shift_odd_i = 0, edges 2, 4, ..., 2N are the shifting edges. With shift_odd_i = 1, edges 1, 3, ..., 2N+1 are the shifting edges. In that mode edge 1 only clears the accumulator, and the N bits are decided at edges 3 to 2N+1. The closing pulse at edge 2N+1 comes from the master's final prescaler expiry.
- R5: The word length is N = word_len_m1_i + 1, where word_len_m1_i ranges from 0 to 31. The first decided bit lands in bit N-1 of rx_word_o and the last in bit 0. Bits above N-1 are zero.
- R6: word_done_o is high for exactly one clock: the cycle after the clock that registers the last shifting edge. rx_word_o takes the new word in that same cycle and otherwise holds its value, which includes the whole of the next transfer.
- R7: If MISO, driven to a bit's value, is inverted for at most p of that bit's samples, the decided bit keeps the driven value.
- R8: The prescaler value, edge selector and word length are taken only at the start. Changing them during a transfer has no effect. Edge pulses while no transfer is running change neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miso_i | input | 1 | Serial data from the slave |
| xfer_start_i | input | 1 | One-clock pulse that begins a transfer |
| sck_edge_i | input | 1 | One-clock pulse per SCK edge from the master's edge logic |
| presc_max_i | input | 4 | Prescaler maximum value p (1 to 15), p+1 clocks per SCK half-period |
| shift_odd_i | input | 1 | Edge roles: 0 = even edges shift, 1 = odd edges shift |
| word_len_m1_i | input | 5 | Word length minus one |
| rx_word_o | output | 32 | Last completed received word, right-aligned |
| word_done_o | output | 1 | One-clock pulse when a new word is published |

## Verification
Three things happen in the same shifting-edge clock: the bit is decided from the count, the accumulator is cleared, and that cycle's MISO sample is thrown away. On the last bit, the publication of the word falls in that clock as well. The bench drives MISO to the inverse of the current bit exactly in every shifting-edge cycle. It also runs frames with the glitch length set so that each bit sits exactly on the p versus p+1 threshold. In those frames, a sample counted one cycle early or late, or a clear that comes a cycle off, flips bits and shows up as a word mismatch. The pulse timing and the holding of the word are judged at the cycle after the last shifting edge and during the following transfer.

// File: rtl/spi_rx_vote_pkg.sv
package spi_rx_vote_pkg;

  // Transfer sequencing state of the receive controller
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_t;

  localparam int unsigned DEF_MAX_BITS = 32;
  localparam int unsigned DEF_PRESC_W  = 4;
  localparam int unsigned DEF_ACC_W    = 6;

endpackage

// File: rtl/spi_rx_vote_rst.sv
module spi_rx_vote_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/spi_rx_vote_acc.sv
module spi_rx_vote_acc #(
  parameter int unsigned PRESC_W = 4,
  parameter int unsigned ACC_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic               miso_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               bit_o
);

  localparam logic [ACC_W-1:0] ACC_FULL = {ACC_W{1'b1}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;
  logic             at_full;

  assign at_full = (acc_q == ACC_FULL);
  assign acc_en  = clr_i | (run_i & miso_i & ~at_full);

  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (run_i && miso_i && !at_full) begin
      acc_d = acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  // Majority decision against the prescaler value
  assign bit_o = (acc_q > ACC_W'(presc_i));

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R2
  acc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && !clr_i) |=> (acc_q == ACC_FULL));

  // R2
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/spi_rx_vote_ctrl.sv
module spi_rx_vote_ctrl
  import spi_rx_vote_pkg::*;
#(
  parameter int unsigned PRESC_W = 4,
  parameter int unsigned LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               edge_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               shift_odd_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic               run_o,
  output logic               clr_o,
  output logic               shift_o,
  output logic               last_o
);

  rx_state_t          state_q, state_d;
  logic               odd_q, odd_d;
  logic               lead_q, lead_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [PRESC_W-1:0] presc_q;
  logic               mode_q;
  logic [LEN_W-1:0]   len_q;
  logic               is_shift_edge;
  logic               running;

  assign running       = (state_q == RX_RUN);
  assign is_shift_edge = running & edge_i & (mode_q ? odd_q : ~odd_q);

  always_comb begin
    state_d = state_q;
    odd_d   = odd_q;
    lead_d  = lead_q;
    cnt_d   = cnt_q;
    shift_o = 1'b0;
    last_o  = 1'b0;
    if (start_i) begin
      state_d = RX_RUN;
      odd_d   = 1'b1;
      lead_d  = shift_odd_i;
      cnt_d   = '0;
    end else if (running && edge_i) begin
      odd_d = ~odd_q;
      if (is_shift_edge) begin
        if (lead_q) begin
          lead_d = 1'b0;
        end else begin
          shift_o = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == len_q) begin
            last_o  = 1'b1;
            state_d = RX_IDLE;
          end
        end
      end
    end
  end

  assign clr_o   = start_i | is_shift_edge;
  assign run_o   = running;
  assign presc_o = presc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      odd_q   <= 1'b1;
      lead_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      odd_q   <= odd_d;
      lead_q  <= lead_d;
      cnt_q   <= cnt_d;
    end
  end

  // Settings are captured only in the start cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      mode_q  <= 1'b0;
      len_q   <= '0;
    end else if (start_i) begin
      presc_q <= presc_i;
      mode_q  <= shift_odd_i;
      len_q   <= len_i;
    end
  end

  // R4
  shift_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |-> (running && edge_i));

  // R5
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q <= len_q));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(presc_q) && $stable(len_q) && $stable(mode_q)));

  // R8
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_i) |=> (state_q == RX_IDLE));

endmodule

// File: rtl/spi_rx_vote_shreg.sv
module spi_rx_vote_shreg #(
  parameter int unsigned MAX_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                shift_i,
  input  logic                last_i,
  input  logic                bit_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic                done_o
);

  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [MAX_BITS-1:0] word_q;
  logic                done_q;
  logic                sh_en;

  assign sh_en = start_i | shift_i;

  always_comb begin
    sh_d = {sh_q[MAX_BITS-2:0], bit_i};
    if (start_i) begin
      sh_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (last_i) begin
      word_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= last_i;
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  // R6
  publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> (done_q && (word_q == $past(sh_d))));

endmodule

// File: rtl/spi_rx_vote.sv
module spi_rx_vote
  import spi_rx_vote_pkg::*;
#(
  parameter int unsigned MAX_BITS = DEF_MAX_BITS,
  parameter int unsigned PRESC_W  = DEF_PRESC_W,
  parameter int unsigned ACC_W    = DEF_ACC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        miso_i,
  input  logic                        xfer_start_i,
  input  logic                        sck_edge_i,
  input  logic [PRESC_W-1:0]          presc_max_i,
  input  logic                        shift_odd_i,
  input  logic [$clog2(MAX_BITS)-1:0] word_len_m1_i,
  output logic [MAX_BITS-1:0]         rx_word_o,
  output logic                        word_done_o
);

  localparam int unsigned LEN_W = $clog2(MAX_BITS);

  logic               rst_sync_n;
  logic [PRESC_W-1:0] presc_cap;
  logic               run;
  logic               clr;
  logic               shift_evt;
  logic               last_evt;
  logic               vote_bit;

  spi_rx_vote_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_rx_vote_ctrl #(.PRESC_W(PRESC_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (xfer_start_i),
    .edge_i      (sck_edge_i),
    .presc_i     (presc_max_i),
    .shift_odd_i (shift_odd_i),
    .len_i       (word_len_m1_i),
    .presc_o     (presc_cap),
    .run_o       (run),
    .clr_o       (clr),
    .shift_o     (shift_evt),
    .last_o      (last_evt)
  );

  spi_rx_vote_acc #(.PRESC_W(PRESC_W), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (run),
    .clr_i   (clr),
    .miso_i  (miso_i),
    .presc_i (presc_cap),
    .bit_o   (vote_bit)
  );

  spi_rx_vote_shreg #(.MAX_BITS(MAX_BITS)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (xfer_start_i),
    .shift_i (shift_evt),
    .last_i  (last_evt),
    .bit_i   (vote_bit),
    .word_o  (rx_word_o),
    .done_o  (word_done_o)
  );

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    word_done_o |=> !word_done_o);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !word_done_o |-> $stable(rx_word_o));

endmodule

// File: tb/spi_rx_vote_bench.sv
module spi_rx_vote_bench;

  logic        clk;
  logic        rst_n;
  logic        miso;
  logic        start;
  logic        sck_edge;
  logic [3:0]  presc;
  logic        shift_odd;
  logic [4:0]  len_m1;
  logic [31:0] rx_word;
  logic        done;

  int          n_tests;
  int          n_fail;
  logic [31:0] exp_q[$];
  logic [31:0] last_word;

  spi_rx_vote u_spi_rx_vote (
    .clk           (clk),
    .rst_n         (rst_n),
    .miso_i        (miso),
    .xfer_start_i  (start),
    .sck_edge_i    (sck_edge),
    .presc_max_i   (presc),
    .shift_odd_i   (shift_odd),
    .word_len_m1_i (len_m1),
    .rx_word_o     (rx_word),
    .word_done_o   (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Majority outcome of one bit period with g leading samples inverted
  function automatic bit decide(input bit v, input int g, input int p);
    int total;
    int highs;
    total = 2 * (p + 1) - 1;
    highs = v ? (total - g) : g;
    return highs > p;
  endfunction

  // Monitor: pops expected words as completions appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected completion", rx_word, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(rx_word == e, "R2/R5 received word", rx_word, e);
      end
    end
  end

  task automatic run_frame(input logic [31:0] word, input int len, input int p,
                           input bit mode, input int g, input bit disturb);
    int          nb;
    int          h;
    int          ne;
    logic [31:0] e;
    nb = len + 1;
    h  = p + 1;
    ne = mode ? (2 * nb + 1) : (2 * nb);
    e  = '0;
    for (int b = 0; b < nb; b++) begin
      e = {e[30:0], decide(word[nb-1-b], g, p)};
    end
    exp_q.push_back(e);

    @(negedge clk);
    presc     = 4'(p);
    len_m1    = 5'(len);
    shift_odd = mode;
    start     = 1'b1;
    sck_edge  = 1'b0;
    miso      = 1'b1;
    for (int ei = 1; ei <= ne; ei++) begin
      for (int j = 1; j <= h; j++) begin
        int ph;
        @(negedge clk);
        start    = 1'b0;
        sck_edge = (j == h);
        ph       = mode ? ei - 1 : ei;
        if (ph == 0) begin
          miso = 1'b1;
        end else begin
          int b2;
          bit hb;
          bit v;
          b2 = (ph - 1) / 2;
          hb = (ph % 2) == 0;
          v  = word[nb-1-b2];
          if (hb && j == h) begin
            miso = ~v;
          end else begin
            int s;
            s    = hb ? (h + j - 1) : (j - 1);
            miso = (s < g) ? ~v : v;
          end
        end
        if (ei == 1 && j == 1) begin
          // R6: previous word still held during this transfer
          check(rx_word == last_word && !done, "R6 hold during transfer",
                rx_word, last_word);
        end
        if (disturb && ei == 2 && j == 1) begin
          // R8: settings changed mid-transfer
          presc     = 4'(15 - p);
          len_m1    = 5'(31 - len);
          shift_odd = ~mode;
        end
      end
    end
    @(negedge clk);
    sck_edge = 1'b0;
    check(done == 1'b1, "R6 pulse in cycle after last shift edge", 32'(done), 32'h1);
    check(rx_word == e, "R6 word published with pulse", rx_word, e);
    @(negedge clk);
    check(done == 1'b0, "R6 pulse lasts one clock", 32'(done), 32'h0);
    last_word = e;
  endtask

  task automatic idle_edges();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sck_edge = k[0];
      miso     = k[1];
    end
    @(negedge clk);
    sck_edge = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_word == last_word && !done, "R8 idle edges ignored", rx_word, last_word);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    last_word = '0;
    rst_n     = 1'b0;
    miso      = 1'b0;
    start     = 1'b0;
    sck_edge  = 1'b0;
    presc     = 4'd3;
    shift_odd = 1'b0;
    len_m1    = 5'd7;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(rx_word == 32'h0, "R1 word after reset", rx_word, 32'h0);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'h0);

    // R4 even edges shift; R5 8-bit word
    run_frame(32'hA5, 7, 3, 1'b0, 0, 1'b0);
    // R4 odd edges shift, lead edge clears only
    run_frame(32'h3C, 7, 3, 1'b1, 0, 1'b0);
    // R5 full 32-bit word, fastest ratio
    run_frame(32'hDEADBEEF, 31, 1, 1'b0, 0, 1'b0);
    // R5 single bit, slowest ratio, upper bits stay zero
    run_frame(32'hFFFFFFFF, 0, 15, 1'b1, 0, 1'b0);
    // R7 glitches of p samples
    run_frame(32'hB2, 7, 5, 1'b0, 5, 1'b0);
    run_frame(32'h9A7, 11, 2, 1'b1, 2, 1'b0);
    // R2/R3 threshold: p+1 highs give one
    run_frame(32'hF0, 7, 4, 1'b0, 4, 1'b0);
    // R2/R3 threshold: one more inverted flips every bit
    run_frame(32'hF0, 7, 4, 1'b0, 5, 1'b0);
    run_frame(32'h5A, 7, 7, 1'b1, 8, 1'b0);
    // R8 mid-transfer setting changes
    run_frame(32'h1234, 15, 2, 1'b0, 1, 1'b1);
    idle_edges();
    run_frame(32'h00C3, 9, 6, 1'b1, 6, 1'b1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6 every transfer completed", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule